// File: doc/BRIEF.md
# Switching Surface Controller with Current Limit

This block drives the high-side switch of a synchronous buck stage while a transient is being handled. A supervisor selects it through an enable input. The block then evaluates a linear switching surface built from the quantised output-voltage error and an estimate of the capacitor current. The output goes high while the surface value is negative. The sign convention suits a load step-up. While the enable is low, the block passes the PWM command through unchanged.

An optional current-limit mode protects the inductor. When the capacitor-current estimate reaches the permitted ceiling, the switch is forced off. The block then slides along the ceiling with a hysteresis band, which bounds the switching rate. A second, saturated surface passes through the origin and ends the limiting phase with a single turn-off.

Slopes are signed fixed-point numbers with `FRAC_W` fractional bits. They scale the current estimate into error LSBs. Every decision is registered once per sample clock.

Top module: `ssc_curlim_ctrl`

## Requirements
- R1: With `enable` high and the block in surface mode, the surface value is S = err + floor(slope·ic_est / 2^FRAC_W). `c1_out` becomes 1 when S < 0 and 0 when S ≥ 0.
- R2: `c1_out` is registered. A change at the inputs is visible only after the next rising clock edge.
- R3: While `enable` is low, `c1_out` equals `pwm_in` one clock later and the block leaves current-limit mode.
- R4: With `enable` and `limit_en` high, `ic_est ≥ ic_max` forces `c1_out` to 0 and places the block in current-limit mode.
- R5: In current-limit mode, `c1_out` turns on only when `ic_est ≤ ic_max − ic_hyst`. Strictly inside the band, it holds its previous value.
- R6: In current-limit mode, a saturated surface Ssat = err + floor(sat_slope·ic_est / 2^FRAC_W) ≥ 0 turns `c1_out` off and returns the block to surface mode. This exit takes priority over the hysteresis turn-on.
- R7: With `limit_en` low, current-limit mode is never entered, and a block already in it returns to surface mode.
- R8: Synchronous active-low reset leaves `c1_out` at 0 and the block in surface mode.
- R9: Truncation of the slope product rounds toward minus infinity. A product of −1/2^FRAC_W therefore contributes −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Surface control selected by the supervisor |
| pwm_in | input | 1 | PWM switch command, passed through while disabled |
| limit_en | input | 1 | Enables current-limit mode |
| err | input | ERR_W | Signed output-voltage error in ADC LSBs |
| ic_est | input | IC_W | Signed capacitor-current estimate |
| slope | input | SLOPE_W | Signed surface slope, FRAC_W fractional bits |
| sat_slope | input | SLOPE_W | Signed saturated-surface slope, FRAC_W fractional bits |
| ic_max | input | IC_W | Signed capacitor-current ceiling |
| ic_hyst | input | IC_W | Unsigned hysteresis below the ceiling |
| c1_out | output | 1 | Registered high-side switch command |

## Verification
The bench uses the defaults: a 10-bit error, 12-bit current and slope, and 8 fractional bits. With these values, a slope of 256 is unity, and a slope of −1 makes the floor-versus-zero truncation corner decide the output bit. A zero saturated slope reduces Ssat to the error alone. This lets the exit from limiting be steered independently of the hysteresis band. With a ceiling of 100 and a band of 20, the hold region sits well inside the current range. Inputs inside the band separate a held output from a fresh surface decision, which makes the hidden mode observable at `c1_out`.

// File: rtl/ssc_pkg.sv
// Shared types of the switching surface controller.
package ssc_pkg;
    // Operating mode of the controller
    typedef enum logic {
        MODE_SURF  = 1'b0,
        MODE_CLAMP = 1'b1
    } ssc_mode_e;
endpackage

// File: rtl/ssc_surface.sv
// Linear switching surface: surf = err + floor(slope*ic / 2^FRAC_W).
// Assumes ERR_W <= SLOPE_W + IC_W so the sum width covers the error.
module ssc_surface #(
    parameter int ERR_W   = 10,
    parameter int IC_W    = 12,
    parameter int SLOPE_W = 12,
    parameter int FRAC_W  = 8,
    localparam int PROD_W = SLOPE_W + IC_W,
    localparam int SUM_W  = PROD_W + 1
) (
    input  logic signed [ERR_W-1:0]   err,
    input  logic signed [IC_W-1:0]    ic,
    input  logic signed [SLOPE_W-1:0] slope,
    output logic signed [SUM_W-1:0]   surf
);
    logic signed [PROD_W-1:0] slope_x;
    logic signed [PROD_W-1:0] ic_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    // Scale the current term to error LSBs and add the error
    always_comb begin
        slope_x = {{(PROD_W-SLOPE_W){slope[SLOPE_W-1]}}, slope};
        ic_x    = {{(PROD_W-IC_W){ic[IC_W-1]}}, ic};
        prod    = slope_x * ic_x;
        scaled  = prod >>> FRAC_W;
        surf    = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err}
                + {scaled[PROD_W-1], scaled};
    end
endmodule

// File: rtl/ssc_limit_band.sv
// Current-limit comparators: ceiling reached, and current at or below
// the lower hysteresis threshold. The hysteresis is treated as unsigned.
module ssc_limit_band #(
    parameter int IC_W = 12,
    localparam int CW  = IC_W + 2
) (
    input  logic signed [IC_W-1:0] ic,
    input  logic signed [IC_W-1:0] ic_max,
    input  logic        [IC_W-1:0] ic_hyst,
    output logic                   at_limit,
    output logic                   below_band
);
    logic signed [CW-1:0] ic_w;
    logic signed [CW-1:0] max_w;
    logic signed [CW-1:0] low_w;

    // Widen operands and compare against both thresholds
    always_comb begin
        ic_w       = {{2{ic[IC_W-1]}}, ic};
        max_w      = {{2{ic_max[IC_W-1]}}, ic_max};
        low_w      = max_w - $signed({2'b00, ic_hyst});
        at_limit   = ic_w >= max_w;
        below_band = ic_w <= low_w;
    end
endmodule

// File: rtl/ssc_curlim_ctrl.sv
// Switching surface controller with inductor-current limiting.
// Assumes synchronous active-low reset and one decision per sample clock;
// c1_out is registered, so decisions appear one clock after their inputs.
module ssc_curlim_ctrl #(
    parameter int ERR_W   = 10,
    parameter int IC_W    = 12,
    parameter int SLOPE_W = 12,
    parameter int FRAC_W  = 8,
    localparam int SUM_W  = SLOPE_W + IC_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      pwm_in,
    input  logic                      limit_en,
    input  logic signed [ERR_W-1:0]   err,
    input  logic signed [IC_W-1:0]    ic_est,
    input  logic signed [SLOPE_W-1:0] slope,
    input  logic signed [SLOPE_W-1:0] sat_slope,
    input  logic signed [IC_W-1:0]    ic_max,
    input  logic        [IC_W-1:0]    ic_hyst,
    output logic                      c1_out
);
    import ssc_pkg::*;

    logic signed [SUM_W-1:0] s_main;
    logic signed [SUM_W-1:0] s_sat;
    logic                    at_limit;
    logic                    below_band;
    ssc_mode_e               mode_q, mode_d;
    logic                    c1_d;

    ssc_surface #(.ERR_W(ERR_W), .IC_W(IC_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W))
        u_main (.err(err), .ic(ic_est), .slope(slope), .surf(s_main));

    ssc_surface #(.ERR_W(ERR_W), .IC_W(IC_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W))
        u_sat (.err(err), .ic(ic_est), .slope(sat_slope), .surf(s_sat));

    ssc_limit_band #(.IC_W(IC_W))
        u_band (.ic(ic_est), .ic_max(ic_max), .ic_hyst(ic_hyst),
                .at_limit(at_limit), .below_band(below_band));

    // Next mode and next switch command
    always_comb begin
        mode_d = mode_q;
        c1_d   = c1_out;
        if (!enable) begin
            mode_d = MODE_SURF;
            c1_d   = pwm_in;
        end else if (!limit_en) begin
            mode_d = MODE_SURF;
            c1_d   = s_main < 0;
        end else if (mode_q == MODE_CLAMP) begin
            if (s_sat >= 0) begin
                mode_d = MODE_SURF;
                c1_d   = 1'b0;
            end else if (at_limit) begin
                c1_d   = 1'b0;
            end else if (below_band) begin
                c1_d   = 1'b1;
            end
        end else if (at_limit) begin
            mode_d = MODE_CLAMP;
            c1_d   = 1'b0;
        end else begin
            c1_d   = s_main < 0;
        end
    end

    // Register mode and output once per sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SURF;
            c1_out <= 1'b0;
        end else begin
            mode_q <= mode_d;
            c1_out <= c1_d;
        end
    end

    AST_DIS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (c1_out == $past(pwm_in)));                               // R3
    AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (mode_q == MODE_SURF));                                   // R3
    AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && limit_en && at_limit) |=> !c1_out);                        // R4
    AST_SURF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode_q == MODE_SURF && !(limit_en && at_limit))
            |=> (c1_out == ($past(s_main) < 0)));                             // R1
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && limit_en && mode_q == MODE_CLAMP && s_sat < 0
            && !at_limit && !below_band) |=> $stable(c1_out));                // R5
    AST_SAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && limit_en && mode_q == MODE_CLAMP && s_sat >= 0)
            |=> (!c1_out && mode_q == MODE_SURF));                            // R6
    AST_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_en |=> (mode_q == MODE_SURF));                                 // R7
endmodule

// File: tb/tb_ssc_curlim_ctrl.sv
module tb_ssc_curlim_ctrl;
    localparam int ERR_W = 10, IC_W = 12, SLOPE_W = 12, FRAC_W = 8;

    logic clk = 1'b0;
    logic rst_n, enable, pwm_in, limit_en;
    logic signed [ERR_W-1:0]   err;
    logic signed [IC_W-1:0]    ic_est, ic_max;
    logic signed [SLOPE_W-1:0] slope, sat_slope;
    logic        [IC_W-1:0]    ic_hyst;
    logic c1_out;
    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    ssc_curlim_ctrl #(.ERR_W(ERR_W), .IC_W(IC_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W))
        dut (.clk(clk), .rst_n(rst_n), .enable(enable), .pwm_in(pwm_in),
             .limit_en(limit_en), .err(err), .ic_est(ic_est), .slope(slope),
             .sat_slope(sat_slope), .ic_max(ic_max), .ic_hyst(ic_hyst),
             .c1_out(c1_out));

    // Reference: surface sign with floor division
    function automatic logic ref_on(int e, int i, int s);
        int p, q;
        p = s * i;
        q = (p >= 0) ? p / 256 : -((-p + 255) / 256);
        return (e + q) < 0;
    endfunction

    task automatic check(input logic exp, input string req);
        n_tests++;
        if (c1_out !== exp) begin
            n_fail++;
            $display("FAIL %s: c1_out=%b expected %b", req, c1_out, exp);
        end
    endtask

    // Apply inputs at a falling edge, sample after the next rising edge
    task automatic step(input int e, input int i, input logic exp, input string req);
        err = ERR_W'(e);
        ic_est = IC_W'(i);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1; pwm_in = 1'b1; limit_en = 1'b0;
        err = -10'sd50; ic_est = '0; slope = 12'sd256; sat_slope = '0;
        ic_max = 12'sd100; ic_hyst = 12'd20;
        repeat (2) @(negedge clk);
        check(1'b0, "R8");
        rst_n = 1'b1;
    endtask

    task automatic t_surface();
        slope = 12'sd256;
        step(-5, 3, ref_on(-5, 3, 256), "R1");
        step(-2, 3, ref_on(-2, 3, 256), "R1");
        step(-3, 3, 1'b0, "R1");
        slope = 12'sd128;
        step(-1, 3, 1'b0, "R1");
        step(-2, 3, 1'b1, "R1");
    endtask

    task automatic t_floor();
        slope = -12'sd1;
        step(0, 1, 1'b1, "R9");
        step(0, 0, 1'b0, "R9");
    endtask

    task automatic t_latency();
        slope = 12'sd256;
        step(-9, 0, 1'b1, "R2");
        err = 10'sd9;
        #1 check(1'b1, "R2");
        @(negedge clk);
        check(1'b0, "R2");
    endtask

    task automatic t_disable();
        enable = 1'b0; pwm_in = 1'b1;
        step(5, 0, 1'b1, "R3");
        pwm_in = 1'b0;
        step(-50, 0, 1'b0, "R3");
        enable = 1'b1;
    endtask

    task automatic t_limit();
        slope = '0; sat_slope = '0; limit_en = 1'b1;
        step(-50, 10, 1'b1, "R4");
        step(-50, 100, 1'b0, "R4");
        step(-50, 90, 1'b0, "R5");
        step(-50, 80, 1'b1, "R5");
        step(-50, 90, 1'b1, "R5");
        step(-50, 100, 1'b0, "R5");
        step(5, 50, 1'b0, "R6");
        step(-50, 90, 1'b1, "R6");
        step(-50, 100, 1'b0, "R4");
        step(5, 90, 1'b0, "R6");
        step(-50, 90, 1'b1, "R6");
    endtask

    task automatic t_nolimit();
        limit_en = 1'b0;
        step(-50, 150, 1'b1, "R7");
        limit_en = 1'b1;
        step(-50, 100, 1'b0, "R4");
        limit_en = 1'b0;
        step(-50, 90, 1'b1, "R7");
        limit_en = 1'b1;
        step(-50, 90, 1'b1, "R7");
    endtask

    task automatic t_disable_clear();
        step(-50, 100, 1'b0, "R4");
        enable = 1'b0; pwm_in = 1'b0;
        step(-50, 90, 1'b0, "R3");
        enable = 1'b1;
        step(-50, 90, 1'b1, "R3");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_surface();
        t_floor();
        t_latency();
        t_disable();
        t_limit();
        t_nolimit();
        t_disable_clear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule